// File: doc/BRIEF.md
# Rotating Four-SIMD Vector Issue Stage

This block is the vector issue stage of one compute unit. The unit holds four SIMD units that share this stage, and each SIMD hosts up to eight wavefront slots. A two-bit turn counter advances on every clock and names the one SIMD allowed to issue in that cycle. Within that SIMD the stage takes the oldest wavefront that is ready and whose SIMD is no longer occupied, and it issues that wavefront's single instruction word. A wavefront carries 64 work-items that run 16 lanes at a time, so one issued instruction holds its SIMD for four cycles. The four SIMDs therefore each accept one instruction every four cycles, offset from each other by one cycle.

Age is kept per SIMD. After reset, a lower slot index counts as older. When a wavefront is launched into a slot (the allocate input), that slot becomes the youngest of its SIMD. The issue result is registered. It appears on the outputs one clock after the edge at which the choice is made.

Top module: `issue_rot_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `issue_valid` is 0. The first clock edge after reset considers SIMD 0. Reset restores the age order in which a lower slot index is older.
- R2: The turn visits SIMDs 0, 1, 2, 3, 0, … and advances one step on every clock edge, whether or not anything issues. An issue made at a given edge reports the SIMD whose turn it was.
- R3: If no slot of the SIMD whose turn it is has its ready bit set, nothing issues in that cycle. The cycle is not given to another SIMD. The ready bit of slot w on SIMD s is `wave_ready[s*8+w]`.
- R4: Among the ready slots of the selected SIMD, the oldest one issues. With the reset age order, that is the lowest ready slot index.
- R5: An allocation to (SIMD, slot) makes that slot younger than every other slot of that SIMD. The change applies from the next clock edge. A selection at the same edge still uses the old order.
- R6: `issue_instr` equals the instruction word that slot presented at the issuing edge. The word for slot w on SIMD s is `wave_instr[(s*8+w)*32 +: 32]`.
- R7: An issue occupies its SIMD for four cycles. The same SIMD, and so the same wavefront, never issues twice within any four consecutive cycles.
- R8: Outputs are registered. A ready bit sampled at edge t affects the outputs only from edge t, and the outputs hold until edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_ready | input | 32 | Ready flag per slot, index simd*8+slot |
| wave_instr | input | 1024 | Instruction word per slot, 32 bits each, same indexing |
| alloc_valid | input | 1 | A wavefront is launched this cycle |
| alloc_simd | input | 2 | SIMD of the launched wavefront |
| alloc_slot | input | 3 | Slot of the launched wavefront |
| issue_valid | output | 1 | An instruction issued |
| issue_simd | output | 2 | SIMD receiving the instruction |
| issue_wave | output | 3 | Slot of the issuing wavefront |
| issue_instr | output | 32 | Issued instruction word |

## Verification
An allocation and an issue decision can land on the same SIMD in the same cycle. The allocation re-ranks ages while the picker reads them. The bench launches into slot 0 of SIMD 0, and into slot 1 of SIMD 1, at the very edges where those SIMDs pick with several slots ready. It then checks that those picks still follow the old order, and that the next turn of each SIMD passes over the newly young slot.

// File: rtl/issue_rot_pkg.sv
package issue_rot_pkg;
  localparam int NUM_SIMD   = 4;
  localparam int SIMD_IDX_W = $clog2(NUM_SIMD);
  localparam int LANES      = 16;
  localparam int WAVE_ITEMS = 64;
  localparam int OCC_CYCLES = WAVE_ITEMS / LANES;
endpackage

// File: rtl/issue_turn_ctr.sv
module issue_turn_ctr #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] turn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      turn <= '0;
    end else if (turn == W'(N - 1)) begin
      turn <= '0;
    end else begin
      turn <= turn + 1'b1;
    end
  end
endmodule

// File: rtl/issue_age_pick.sv
module issue_age_pick #(
  parameter int SLOTS = 8,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [SW-1:0] alloc_slot,
  input  logic [SLOTS-1:0] elig,
  output logic          found,
  output logic [SW-1:0] win_idx
);
  // older_m[i][j] = 1 when slot i is older than slot j
  logic [SLOTS-1:0] older_m [SLOTS];
  logic [SLOTS-1:0] win_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        for (int j = 0; j < SLOTS; j++) begin
          older_m[i][j] <= (i < j);
        end
      end
    end else if (alloc_en) begin
      for (int i = 0; i < SLOTS; i++) begin
        older_m[alloc_slot][i] <= 1'b0;
        older_m[i][alloc_slot] <= (SW'(i) != alloc_slot);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      win_oh[i] = elig[i];
      for (int j = 0; j < SLOTS; j++) begin
        if (elig[j] && older_m[j][i]) begin
          win_oh[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    found   = |win_oh;
    win_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (win_oh[i]) begin
        win_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/issue_occ_track.sv
module issue_occ_track #(
  parameter int OCC = 4,
  localparam int CW = (OCC > 1) ? $clog2(OCC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic free
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (fire) begin
      left <= CW'(OCC - 1);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign free = (left == '0);
endmodule

// File: rtl/issue_rot_top.sv
module issue_rot_top
  import issue_rot_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int INSTR_W = 32,
  parameter int OCC     = OCC_CYCLES,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NW     = NUM_SIMD * SLOTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NW-1:0]           wave_ready,
  input  logic [NW*INSTR_W-1:0]   wave_instr,
  input  logic                    alloc_valid,
  input  logic [SIMD_IDX_W-1:0]   alloc_simd,
  input  logic [SW-1:0]           alloc_slot,
  output logic                    issue_valid,
  output logic [SIMD_IDX_W-1:0]   issue_simd,
  output logic [SW-1:0]           issue_wave,
  output logic [INSTR_W-1:0]      issue_instr
);
  logic [SIMD_IDX_W-1:0] turn;
  logic [NUM_SIMD-1:0]   occ_free;
  logic [NUM_SIMD-1:0]   pick_found;
  logic [SW-1:0]         pick_idx [NUM_SIMD];
  logic                  sel_found;
  logic [SW-1:0]         sel_slot;
  logic [SIMD_IDX_W+SW-1:0] sel_flat;

  issue_turn_ctr #(.N(NUM_SIMD)) u_turn (
    .clk (clk),
    .rst (rst),
    .turn(turn)
  );

  for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
    logic [SLOTS-1:0] elig;
    logic             fire;

    assign elig = wave_ready[s*SLOTS +: SLOTS] & {SLOTS{occ_free[s]}};
    assign fire = sel_found && (turn == SIMD_IDX_W'(s));

    issue_age_pick #(.SLOTS(SLOTS)) u_pick (
      .clk       (clk),
      .rst       (rst),
      .alloc_en  (alloc_valid && (alloc_simd == SIMD_IDX_W'(s))),
      .alloc_slot(alloc_slot),
      .elig      (elig),
      .found     (pick_found[s]),
      .win_idx   (pick_idx[s])
    );

    issue_occ_track #(.OCC(OCC)) u_occ (
      .clk (clk),
      .rst (rst),
      .fire(fire),
      .free(occ_free[s])
    );
  end

  assign sel_found = pick_found[turn];
  assign sel_slot  = pick_idx[turn];
  assign sel_flat  = {turn, sel_slot};

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_simd  <= '0;
      issue_wave  <= '0;
      issue_instr <= '0;
    end else begin
      issue_valid <= sel_found;
      issue_simd  <= turn;
      issue_wave  <= sel_slot;
      issue_instr <= wave_instr[sel_flat*INSTR_W +: INSTR_W];
    end
  end
endmodule

// File: rtl/issue_rot_checker.sv
module issue_rot_checker
  import issue_rot_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int INSTR_W = 32,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NW     = NUM_SIMD * SLOTS
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NW-1:0]         wave_ready,
  input logic [NW*INSTR_W-1:0] wave_instr,
  input logic                  issue_valid,
  input logic [SIMD_IDX_W-1:0] issue_simd,
  input logic [SW-1:0]         issue_wave,
  input logic [INSTR_W-1:0]    issue_instr
);
  logic [NW-1:0]         prev_ready;
  logic [NW*INSTR_W-1:0] prev_instr;

  always_ff @(posedge clk) begin
    prev_ready <= wave_ready;
    prev_instr <= wave_instr;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !issue_valid); // R1
  AST_TURN_STEP: assert property (@(posedge clk) disable iff (rst)
    issue_valid && $past(issue_valid) |->
      issue_simd == SIMD_IDX_W'($past(issue_simd) + 1'b1)); // R2
  AST_ISSUER_READY: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> prev_ready[{issue_simd, issue_wave}]); // R3
  AST_INSTR_MATCH: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> issue_instr == prev_instr[{issue_simd, issue_wave}*INSTR_W +: INSTR_W]); // R6
  AST_GAP_ONE: assert property (@(posedge clk) disable iff (rst)
    issue_valid && $past(issue_valid, 1) |-> issue_simd != $past(issue_simd, 1)); // R7
  AST_GAP_TWO: assert property (@(posedge clk) disable iff (rst)
    issue_valid && $past(issue_valid, 2) |-> issue_simd != $past(issue_simd, 2)); // R7
  AST_GAP_THREE: assert property (@(posedge clk) disable iff (rst)
    issue_valid && $past(issue_valid, 3) |-> issue_simd != $past(issue_simd, 3)); // R7
endmodule

bind issue_rot_top issue_rot_checker #(.SLOTS(SLOTS), .INSTR_W(INSTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wave_ready (wave_ready),
  .wave_instr (wave_instr),
  .issue_valid(issue_valid),
  .issue_simd (issue_simd),
  .issue_wave (issue_wave),
  .issue_instr(issue_instr)
);

// File: tb/test_issue_rot_top.sv
module test_issue_rot_top;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   wave_ready = '0;
  logic [1023:0] wave_instr;
  logic          alloc_valid = 1'b0;
  logic [1:0]    alloc_simd = '0;
  logic [2:0]    alloc_slot = '0;
  logic          issue_valid;
  logic [1:0]    issue_simd;
  logic [2:0]    issue_wave;
  logic [31:0]   issue_instr;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  issue_rot_top i_issue_rot_top (
    .clk(clk), .rst(rst), .wave_ready(wave_ready), .wave_instr(wave_instr),
    .alloc_valid(alloc_valid), .alloc_simd(alloc_simd), .alloc_slot(alloc_slot),
    .issue_valid(issue_valid), .issue_simd(issue_simd), .issue_wave(issue_wave),
    .issue_instr(issue_instr)
  );

  // {ready, alloc_v, alloc_simd, alloc_slot, exp_v, exp_simd, exp_wave}
  localparam logic [43:0] VEC [16] = '{
    {32'h0000_0028, 1'b0, 2'd0, 3'd0, 1'b1, 2'd0, 3'd3}, // R4 turn0
    {32'h0000_0001, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R3 turn1 not donated
    {32'h0180_0000, 1'b0, 2'd0, 3'd0, 1'b1, 2'd2, 3'd7}, // R2 turn2
    {32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0, 1'b1, 2'd3, 3'd0}, // R4 turn3
    {32'hFFFF_FFFF, 1'b1, 2'd0, 3'd0, 1'b1, 2'd0, 3'd0}, // R5 alloc same edge
    {32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 3'd0}, // R2
    {32'h0000_0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R8 drops
    {32'h0000_0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R3
    {32'h0000_0003, 1'b0, 2'd0, 3'd0, 1'b1, 2'd0, 3'd1}, // R5 slot0 young
    {32'h0000_0600, 1'b1, 2'd1, 3'd1, 1'b1, 2'd1, 3'd1}, // R5 old order
    {32'h0000_0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R3
    {32'h0000_0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R3
    {32'h0000_0600, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0}, // R3 turn0
    {32'h0000_0600, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 3'd2}, // R5 slot1 young
    {32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0, 1'b1, 2'd2, 3'd0}, // R6
    {32'h8000_0000, 1'b0, 2'd0, 3'd0, 1'b1, 2'd3, 3'd7}  // R6
  };

  task automatic chk(input string req, input logic ev, input logic [1:0] es,
                     input logic [2:0] ew);
    logic [31:0] ei;
    ei = 32'hC0DE_0000 | {27'd0, es, ew};
    n_run++;
    if (issue_valid !== ev) begin
      n_fail++;
      $display("FAIL %s valid act=%0b exp=%0b", req, issue_valid, ev);
    end else if (ev && (issue_simd !== es || issue_wave !== ew || issue_instr !== ei)) begin
      n_fail++;
      $display("FAIL %s act=%0d/%0d/%h exp=%0d/%0d/%h", req, issue_simd, issue_wave,
               issue_instr, es, ew, ei);
    end
  endtask

  task automatic step(input logic [31:0] rdy, input logic av, input logic [1:0] as_,
                      input logic [2:0] al);
    wave_ready  = rdy;
    alloc_valid = av;
    alloc_simd  = as_;
    alloc_slot  = al;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) wave_instr[i*32 +: 32] = 32'hC0DE_0000 | i;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 reset idle", 1'b0, 2'd0, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][43:12], VEC[k][11], VEC[k][10:9], VEC[k][8:6]);
      chk($sformatf("R2/R3/R4/R5/R6/R8 vec%0d", k), VEC[k][5], VEC[k][4:3], VEC[k][2:0]);
      @(negedge clk);
    end
    // R1: reset mid-run
    rst = 1'b1;
    step(32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0);
    chk("R1 idle in reset", 1'b0, 2'd0, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    step(32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0);
    chk("R1 turn0 and age order restored", 1'b1, 2'd0, 3'd0);
    @(negedge clk);
    // R7: all ready, each SIMD once per four cycles
    for (int k = 0; k < 8; k++) begin
      step(32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0);
      chk("R7 spacing", 1'b1, 2'((k + 1) % 4), 3'd0);
      @(negedge clk);
    end
    // R3: only SIMD 2 ready (turn now at 1)
    for (int k = 0; k < 4; k++) begin
      step(32'h0010_0000, 1'b0, 2'd0, 3'd0);
      chk("R3 only own turn", (k == 1), 2'd2, 3'd4);
      @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule